// File: doc/BRIEF.md
# Multi-channel compare/capture timer

The block keeps a wide free-running system counter and a bank of compare/capture channels. It sits idle with the count at zero until the start task is written. After that the count grows by one on every cycle where the `tick` input is high. Each channel holds a compare value as wide as the counter, split into a low and a high word. While the channel is enabled and the counter is running, the channel matches whenever its compare value is at or below the count. A match sets a sticky event flag and sends out a one-cycle publish pulse. Channel 0 can re-arm itself by adding an interval to its compare value. Every other channel disarms after a match.

Software programs a channel in several ways. It can write the compare words directly. It can write an add register that offsets either the current counter or the current compare value. It can pulse a capture input, which loads the current count into the compare words and disarms compare. The event flags drive several interrupt lines through per-line masks. Each mask has a direct register, a set alias and a clear alias.

The counter controller is a two-state machine. ST_IDLE is the reset state: the count holds at zero and ticks are ignored. The transition ST_IDLE to ST_RUN happens on the start task. It zeroes the count and raises the sticky counter-valid flag. In ST_RUN, a further start task takes the self-transition ST_RUN to ST_RUN and zeroes the count again. In ST_RUN without a start task, the state is kept and the count advances on each tick.

Top module: `cmp_cap_timer`

## Requirements
- R1: After reset the state is ST_IDLE, the counter reads 0, and the status word at address 0x00 reads 0. Ticks do not advance the counter in ST_IDLE. A write to 0x00 with bit 0 set moves the block to ST_RUN, zeroes the counter and sets status bit 0. Status bit 0 then stays set until reset.
- R2: In ST_RUN the counter increments by one on each clock cycle where `tick` is high, and holds otherwise. The low 32 bits read at 0x01 and the upper bits read at 0x02.
- R3: A channel matches when it is enabled, the counter is running, and its compare value is less than or equal to the counter. On the clock edge after a match condition, `compare_pulse[ch]` is high for one cycle and the event flag reads 1 at address 0x20+ch. A compare value already in the past therefore fires one cycle after the channel is enabled.
- R4: The channel registers start at base 0x40+4*ch: +0 is the low compare word, +1 is the high word, +2 is the enable register (bit 0), and +3 is the add register. Writing the low word clears the channel's enable. Writing the high word sets it.
- R5: A write to the add register takes an offset in bits 30:0 and a reference select in bit 31. With bit 31 set, the offset is added to the compare value. With bit 31 clear, it is added to the counter. The sum is stored in the compare words and the channel is enabled.
- R6: When channel 0 matches and the interval register at 0x03 is nonzero, the interval is added to its compare value and the channel stays enabled.
- R7: When any channel other than 0 matches, or channel 0 matches with a zero interval, the channel's enable is cleared and its compare value is kept.
- R8: A high `capture_task[ch]` clears the channel's enable and loads the current counter into its compare words. If a match happens in the same cycle, the capture takes precedence: no event flag and no pulse result.
- R9: The high compare word stores only the counter bits above bit 31, which is 20 bits by default. Reads of the high compare word and of the counter's upper word return zeros above that width.
- R10: Interrupt line l has three addresses. The direct mask at 0x08+l replaces the mask. The set alias at 0x0C+l ORs the written bits into the mask. The clear alias at 0x10+l removes the written bits from the mask. Bit ch of a mask selects channel ch. Writing zero to an alias leaves the mask unchanged. Reading either the direct mask or the set alias returns the mask.
- R11: `irq[l]` is the OR over channels of the event flag ANDed with bit ch of line l's mask. The line follows any change of flags or mask within the cycle after the change.
- R12: Writing zero to 0x20+ch clears that channel's event flag. Writing a nonzero value there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one increment per high cycle while running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| capture_task | input | N_CH | Per-channel capture task, one bit per channel |
| compare_pulse | output | N_CH | Per-channel publish pulse on match |
| irq | output | N_IRQ | Interrupt lines |

## Verification
The channel assertions assume the following about the inputs: any write strobe or capture in a cycle decides the channel's next enable ahead of the match. The reload and disarm properties are therefore checked only in cycles with no write and no capture for that channel. The stimulus holds `tick` low except for counted bursts. This keeps the counter frozen at a value the bench knows, so every compare value it programs falls a known distance before or after the count. The random phase disarms and clears every channel before it programs a random set of channels to match at the frozen count. Captures arrive only in a cycle between bus writes.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int ADDR_W = 8;

    localparam int ADR_CTRL  = 8'h00;
    localparam int ADR_CNTLO = 8'h01;
    localparam int ADR_CNTHI = 8'h02;
    localparam int ADR_IVL   = 8'h03;
    localparam int ADR_MASK  = 8'h08;
    localparam int ADR_MSET  = 8'h0C;
    localparam int ADR_MCLR  = 8'h10;
    localparam int ADR_EVT   = 8'h20;
    localparam int ADR_CH    = 8'h40;

    localparam int CH_LO  = 0;
    localparam int CH_HI  = 1;
    localparam int CH_ENA = 2;
    localparam int CH_ADD = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/cct_sys_counter.sv
module cct_sys_counter
    import cct_pkg::*;
#(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    output logic             running,
    output logic             valid_q,
    output logic [CNT_W-1:0] cnt_q
);

    cnt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign running = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        valid_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (start)     cnt_q <= '0;
                    else if (tick) cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    assert_valid_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> (cnt_q == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !start) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
    parameter int CNT_W  = 52,
    parameter int IVL_W  = 32,
    parameter bit RELOAD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [IVL_W-1:0] interval,
    input  logic [31:0]      wr_data,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_ena,
    input  logic             wr_add,
    input  logic             wr_evt,
    input  logic             capture,
    output logic [CNT_W-1:0] cc_q,
    output logic             en_q,
    output logic             evt_q,
    output logic             pulse_q
);

    localparam int HI_W  = CNT_W - 32;
    localparam int OFS_W = 31;

    logic             match;
    logic             reload_on;
    logic             any_wr;
    logic [CNT_W-1:0] add_base;
    logic [CNT_W-1:0] add_sum;
    logic [CNT_W-1:0] reload_sum;

    assign match      = running && en_q && (cc_q <= cnt);
    assign reload_on  = (RELOAD == 1'b1) && (interval != '0);
    assign any_wr     = wr_lo || wr_hi || wr_ena || wr_add;
    assign add_base   = wr_data[31] ? cc_q : cnt;
    assign add_sum    = add_base + CNT_W'(wr_data[OFS_W-1:0]);
    assign reload_sum = cc_q + CNT_W'(interval);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q <= '0;
            en_q <= 1'b0;
        end else if (capture) begin
            cc_q <= cnt;
            en_q <= 1'b0;
        end else if (wr_lo) begin
            cc_q[31:0] <= wr_data;
            en_q       <= 1'b0;
        end else if (wr_hi) begin
            cc_q[CNT_W-1:32] <= wr_data[HI_W-1:0];
            en_q             <= 1'b1;
        end else if (wr_add) begin
            cc_q <= add_sum;
            en_q <= 1'b1;
        end else if (wr_ena) begin
            en_q <= wr_data[0];
        end else if (match) begin
            if (reload_on) cc_q <= reload_sum;
            else           en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= match && !capture;
            if (match && !capture)          evt_q <= 1'b1;
            else if (wr_evt && wr_data == 0) evt_q <= 1'b0;
        end
    end

    assert_pulse_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> evt_q);

    assert_lo_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !en_q);

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !capture && !any_wr && reload_on) |=>
        (en_q && cc_q == $past(cc_q) + CNT_W'($past(interval))));

    assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !capture && !any_wr && !reload_on) |=> (!en_q && $stable(cc_q)));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (!en_q && !pulse_q && cc_q == $past(cnt)));

endmodule

// File: rtl/cct_irq_router.sv
module cct_irq_router #(
    parameter int N_CH  = 12,
    parameter int N_IRQ = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0]            flags,
    input  logic [N_IRQ-1:0]           wr_dir,
    input  logic [N_IRQ-1:0]           wr_set,
    input  logic [N_IRQ-1:0]           wr_clr,
    input  logic [N_CH-1:0]            wr_bits,
    output logic [N_IRQ-1:0][N_CH-1:0] masks,
    output logic [N_IRQ-1:0]           irq
);

    for (genvar l = 0; l < N_IRQ; l++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         masks[l] <= '0;
            else if (wr_dir[l]) masks[l] <= wr_bits;
            else if (wr_set[l]) masks[l] <= masks[l] | wr_bits;
            else if (wr_clr[l]) masks[l] <= masks[l] & ~wr_bits;
        end

        assign irq[l] = |(flags & masks[l]);

        assert_set_alias_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_set[l] && !wr_dir[l]) |=>
            ((masks[l] & $past(wr_bits)) == $past(wr_bits)) &&
            ((masks[l] & $past(masks[l])) == $past(masks[l])));

        assert_clr_alias_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr[l] && !wr_dir[l] && !wr_set[l]) |=>
            ((masks[l] & $past(wr_bits)) == '0));
    end

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> (irq == '0));

endmodule

// File: rtl/cmp_cap_timer.sv
module cmp_cap_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 52,
    parameter int N_CH  = 12,
    parameter int N_IRQ = 4,
    parameter int IVL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [N_CH-1:0]   capture_task,
    output logic [N_CH-1:0]   compare_pulse,
    output logic [N_IRQ-1:0]  irq
);

    localparam int HI_W = CNT_W - 32;

    logic                       running;
    logic                       valid;
    logic [CNT_W-1:0]           cnt;
    logic                       start;
    logic [IVL_W-1:0]           interval_q;
    logic [N_CH-1:0]            ch_lo, ch_hi, ch_ena, ch_add, ch_evt;
    logic [N_CH-1:0]            ch_en, evt;
    logic [N_CH-1:0][CNT_W-1:0] ch_cc;
    logic [N_IRQ-1:0]           m_dir, m_set, m_clr;
    logic [N_IRQ-1:0][N_CH-1:0] masks;

    assign start = wr_en && (wr_addr == ADDR_W'(ADR_CTRL)) && wr_data[0];

    cct_sys_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .running (running),
        .valid_q (valid),
        .cnt_q   (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) interval_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(ADR_IVL)) interval_q <= wr_data[IVL_W-1:0];
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch_lo[g]  = wr_en && (wr_addr == ADDR_W'(ADR_CH + 4*g + CH_LO));
        assign ch_hi[g]  = wr_en && (wr_addr == ADDR_W'(ADR_CH + 4*g + CH_HI));
        assign ch_ena[g] = wr_en && (wr_addr == ADDR_W'(ADR_CH + 4*g + CH_ENA));
        assign ch_add[g] = wr_en && (wr_addr == ADDR_W'(ADR_CH + 4*g + CH_ADD));
        assign ch_evt[g] = wr_en && (wr_addr == ADDR_W'(ADR_EVT + g));

        cct_channel #(
            .CNT_W  (CNT_W),
            .IVL_W  (IVL_W),
            .RELOAD (g == 0)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .running  (running),
            .cnt      (cnt),
            .interval (interval_q),
            .wr_data  (wr_data),
            .wr_lo    (ch_lo[g]),
            .wr_hi    (ch_hi[g]),
            .wr_ena   (ch_ena[g]),
            .wr_add   (ch_add[g]),
            .wr_evt   (ch_evt[g]),
            .capture  (capture_task[g]),
            .cc_q     (ch_cc[g]),
            .en_q     (ch_en[g]),
            .evt_q    (evt[g]),
            .pulse_q  (compare_pulse[g])
        );
    end

    for (genvar l = 0; l < N_IRQ; l++) begin : g_msk
        assign m_dir[l] = wr_en && (wr_addr == ADDR_W'(ADR_MASK + l));
        assign m_set[l] = wr_en && (wr_addr == ADDR_W'(ADR_MSET + l));
        assign m_clr[l] = wr_en && (wr_addr == ADDR_W'(ADR_MCLR + l));
    end

    cct_irq_router #(.N_CH(N_CH), .N_IRQ(N_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (evt),
        .wr_dir  (m_dir),
        .wr_set  (m_set),
        .wr_clr  (m_clr),
        .wr_bits (wr_data[N_CH-1:0]),
        .masks   (masks),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_CTRL))  rd_data = {31'b0, valid};
        if (rd_addr == ADDR_W'(ADR_CNTLO)) rd_data = cnt[31:0];
        if (rd_addr == ADDR_W'(ADR_CNTHI)) rd_data = 32'(cnt[CNT_W-1:32]);
        if (rd_addr == ADDR_W'(ADR_IVL))   rd_data = 32'(interval_q);
        for (int l = 0; l < N_IRQ; l++) begin
            if (rd_addr == ADDR_W'(ADR_MASK + l) || rd_addr == ADDR_W'(ADR_MSET + l))
                rd_data = 32'(masks[l]);
        end
        for (int i = 0; i < N_CH; i++) begin
            if (rd_addr == ADDR_W'(ADR_EVT + i))
                rd_data = {31'b0, evt[i]};
            if (rd_addr == ADDR_W'(ADR_CH + 4*i + CH_LO))
                rd_data = ch_cc[i][31:0];
            if (rd_addr == ADDR_W'(ADR_CH + 4*i + CH_HI))
                rd_data = 32'(ch_cc[i][CNT_W-1:32]);
            if (rd_addr == ADDR_W'(ADR_CH + 4*i + CH_ENA))
                rd_data = {31'b0, ch_en[i]};
        end
    end

    assert_high_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(ADR_CNTHI)) |-> ((rd_data >> HI_W) == 32'd0));

endmodule

// File: tb/cmp_cap_timer_tb_top.sv
module cmp_cap_timer_tb_top;

    localparam int CLK_P = 10;
    localparam int N_CH  = 12;
    localparam int N_IRQ = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [7:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [N_CH-1:0]   capture_task = '0;
    logic [N_CH-1:0]   compare_pulse;
    logic [N_IRQ-1:0]  irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cmp_cap_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .capture_task  (capture_task),
        .compare_pulse (compare_pulse),
        .irq           (irq)
    );

    function automatic logic [7:0] cha(input int ch, input int k);
        return 8'(8'h40 + 4*ch + k);
    endfunction

    function automatic logic [N_IRQ-1:0] exp_irq(input logic [N_CH-1:0] fl,
                                                 input logic [N_IRQ-1:0][N_CH-1:0] mk);
        logic [N_IRQ-1:0] r;
        for (int l = 0; l < N_IRQ; l++) r[l] = |(fl & mk[l]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tk(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic cap(input int ch);
        capture_task[ch] = 1'b1;
        @(negedge clk);
        capture_task[ch] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [N_CH-1:0] subset, seen;
        logic [N_IRQ-1:0][N_CH-1:0] mk;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and idle ignores ticks
        rd(8'h01, v); chk("R1 reset count", v, 0);
        rd(8'h00, v); chk("R1 reset status", v, 0);
        chk("R11 reset irq", irq, 0);
        chk("R3 reset pulse", compare_pulse, 0);
        tk(5);
        rd(8'h01, v); chk("R1 idle ignores tick", v, 0);

        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R1 valid set", v, 1);
        rd(8'h01, v); chk("R1 start zero", v, 0);

        // R2 counting
        tk(10);
        rd(8'h01, v); chk("R2 count 10", v, 10);
        repeat (5) @(negedge clk);
        rd(8'h01, v); chk("R2 hold without tick", v, 10);
        rd(8'h02, v); chk("R2 upper word", v, 0);

        // R9 / R4 on channel 1
        wr(cha(1, 1), 32'hFFFF_FFFF);
        rd(cha(1, 1), v); chk("R9 high word masked", v, 32'h000F_FFFF);
        rd(cha(1, 2), v); chk("R4 high write enables", v, 1);
        wr(cha(1, 0), 32'd5);
        rd(cha(1, 2), v); chk("R4 low write disables", v, 0);
        wr(cha(1, 1), 32'd0);
        @(negedge clk);
        chk("R3 past value fires", compare_pulse[1], 1);
        rd(8'h21, v); chk("R3 event flag", v, 1);
        rd(cha(1, 2), v); chk("R7 channel 1 disarms", v, 0);
        @(negedge clk);
        chk("R3 pulse one cycle", compare_pulse[1], 0);
        rd(cha(1, 0), v); chk("R7 value kept", v, 5);

        // R12 event clear
        wr(8'h21, 32'h1);
        rd(8'h21, v); chk("R12 nonzero write ignored", v, 1);
        wr(8'h21, 32'h0);
        rd(8'h21, v); chk("R12 zero write clears", v, 0);

        // R3 equality boundary on channel 2
        wr(cha(2, 0), 32'd11);
        wr(cha(2, 1), 32'd0);
        repeat (3) @(negedge clk);
        rd(8'h22, v); chk("R3 future value waits", v, 0);
        tk(1);
        @(negedge clk);
        chk("R3 equal fires", compare_pulse[2], 1);
        rd(8'h01, v); chk("R2 count 11", v, 11);

        // R5 add register on channel 3
        wr(cha(3, 3), 32'd7);
        rd(cha(3, 0), v); chk("R5 add to counter", v, 18);
        rd(cha(3, 2), v); chk("R5 add enables", v, 1);
        wr(cha(3, 3), 32'h8000_0003);
        rd(cha(3, 0), v); chk("R5 add to compare", v, 21);

        // R6 reload on channel 0
        wr(8'h03, 32'd4);
        wr(cha(0, 0), 32'd12);
        wr(cha(0, 1), 32'd0);
        tk(1);
        @(negedge clk);
        chk("R6 first match pulse", compare_pulse[0], 1);
        rd(cha(0, 0), v); chk("R6 reload value", v, 16);
        rd(cha(0, 2), v); chk("R6 stays enabled", v, 1);
        tk(4);
        @(negedge clk);
        chk("R6 second match pulse", compare_pulse[0], 1);
        rd(cha(0, 0), v); chk("R6 second reload", v, 20);
        wr(8'h03, 32'd0);
        tk(4);
        @(negedge clk);
        chk("R7 zero interval pulse", compare_pulse[0], 1);
        rd(cha(0, 2), v); chk("R7 zero interval disarms", v, 0);
        rd(cha(0, 0), v); chk("R7 zero interval value", v, 20);

        // R8 capture on channel 4
        wr(cha(4, 3), 32'd1000);
        cap(4);
        rd(cha(4, 0), v); chk("R8 capture low", v, 20);
        rd(cha(4, 1), v); chk("R8 capture high", v, 0);
        rd(cha(4, 2), v); chk("R8 capture disarms", v, 0);
        rd(8'h24, v); chk("R8 no event", v, 0);

        // R8 capture beats a same-cycle match on channel 5
        wr(cha(5, 0), 32'd5);
        wr(cha(5, 1), 32'd0);
        cap(5);
        chk("R8 no pulse on conflict", compare_pulse[5], 0);
        rd(8'h25, v); chk("R8 no flag on conflict", v, 0);
        rd(cha(5, 2), v); chk("R8 conflict disarms", v, 0);
        rd(cha(5, 0), v); chk("R8 conflict captured", v, 20);

        // R10 mask aliases
        wr(8'h08, 32'h00F);
        rd(8'h08, v); chk("R10 direct mask", v, 32'h00F);
        wr(8'h0C, 32'h030);
        rd(8'h0C, v); chk("R10 set alias read", v, 32'h03F);
        wr(8'h0C, 32'h0);
        rd(8'h08, v); chk("R10 zero set no effect", v, 32'h03F);
        wr(8'h10, 32'h003);
        rd(8'h08, v); chk("R10 clear alias", v, 32'h03C);
        wr(8'h10, 32'h0);
        rd(8'h08, v); chk("R10 zero clear no effect", v, 32'h03C);

        // R11 random flag and mask patterns
        for (int it = 0; it < 16; it++) begin
            for (int c = 0; c < N_CH; c++) wr(cha(c, 2), 32'd0);
            for (int c = 0; c < N_CH; c++) wr(8'(8'h20 + c), 32'd0);
            chk("R11 no flags no irq", irq, 0);
            subset = N_CH'($urandom);
            for (int c = 0; c < N_CH; c++)
                if (subset[c]) wr(cha(c, 3), 32'd0);
            repeat (2) @(negedge clk);
            seen = '0;
            for (int c = 0; c < N_CH; c++) begin
                rd(8'(8'h20 + c), v);
                seen[c] = v[0];
            end
            chk("R3 random flag set", seen, subset);
            for (int l = 0; l < N_IRQ; l++) begin
                mk[l] = N_CH'($urandom);
                wr(8'(8'h08 + l), 32'(mk[l]));
            end
            chk("R11 irq pattern", irq, exp_irq(subset, mk));
            wr(8'h10, 32'hFFF);
            mk[0] = '0;
            chk("R11 irq after clear alias", irq, exp_irq(subset, mk));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule